// File: doc/BRIEF.md
# Oversampled Serial Receive Engine

The block receives asynchronous serial frames on a single input line. A free-running oversample clock enable, one pulse per sixteenth of a bit by default, drives all timing. While reception is enabled, the engine waits for the idle-high line to fall. It then confirms the start bit half a bit later. After that it samples each data bit, the optional parity bit and a single stop bit at the centre of its bit cell. The assembled word goes into a receive buffer that the surrounding logic reads through a read strobe.

Every completed frame writes the buffer and gives a one-cycle completion pulse, even when the frame is bad. A bad frame also gives a one-cycle error pulse and sets its flags in a three-bit status word (parity, framing, overrun). Software-side logic reads the status word directly. It clears when the buffer is read, and each new completion replaces it. Dropping the enable abandons a frame in progress and raises no event.

Top module: `serial_rx_engine`

## Requirements
- R1: After reset `rx_data` is 0, `rx_status` is 0, and `rx_done` and `rx_err` are low.
- R2: The falling edge is checked again OSR/2 oversample ticks after it was detected. If the line is high again at that point, the engine returns to waiting and raises no pulse.
- R3: A frame is a start bit, then the data bits LSB first, then a parity bit when parity is on, then one stop bit. Each bit is sampled OSR ticks after the previous sample. `len8`=1 selects 8 data bits and `len8`=0 selects 7 bits, with bit 7 of `rx_data` reading 0.
- R4: `par_mode` 2'b01 selects even parity, 2'b10 selects odd, and 2'b00 or 2'b11 selects none. A parity bit that breaks the selected rule sets `rx_status[0]`.
- R5: A stop-bit sample that is low sets `rx_status[1]` (framing).
- R6: A frame that completes while the previous word has not been read sets `rx_status[2]` (overrun). A read in the same cycle counts as a read.
- R7: Every completed frame writes its word to `rx_data` and raises `rx_done` for exactly one cycle, whether or not it had an error.
- R8: `rx_err` pulses for one cycle, together with `rx_done`, exactly when at least one status flag of that frame is set.
- R9: A `buf_rd` pulse clears `rx_status` to 0. A new completion replaces all three flags with the new frame's flags.
- R10: While `rx_en` is 0 the engine is idle. Dropping it mid-frame raises no pulse and leaves `rx_data` and `rx_status` unchanged. Raising it starts the search for a start bit.
- R11: Only one stop bit is checked, so a start bit that follows one stop bit directly is received as the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversample clock enable, OSR pulses per bit |
| rx_en | input | 1 | Receive enable |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_mode | input | 2 | 00/11 none, 01 even, 10 odd |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| buf_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | 8 | Receive buffer |
| rx_status | output | 3 | {overrun, framing, parity} flags |
| rx_done | output | 1 | One-cycle frame completion pulse |
| rx_err | output | 1 | One-cycle frame error pulse |

## Verification
The bench builds the engine with OSR=8 and DATA_W=8 and pulses the oversample enable on every second clock. One bit therefore lasts 16 clocks, so many random frames of both lengths and all parity modes fit in a short run. With OSR=8, the start confirmation falls four ticks after the edge and each data sample falls eight ticks after the previous one. The short start glitch, the truncated low stop bit and the enable dropped mid-frame can then be placed precisely against those sample points.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  typedef struct packed {
    logic overrun;
    logic framing;
    logic parity;
  } rx_flags_t;

endpackage

// File: rtl/rx_sync2.sv
module rx_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      d_sync <= RESET_VAL;
    end else begin
      meta_q <= d_async;
      d_sync <= meta_q;
    end
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              line,
  input  logic              len8,
  input  logic [1:0]        par_mode,
  output logic              frame_evt,
  output logic [DATA_W-1:0] frame_word,
  output logic              frame_perr,
  output logic              frame_ferr,
  output logic              start_reject
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int IW   = $clog2(DATA_W + 2);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     bidx;
  logic [DATA_W-1:0] shreg;
  logic              par_q;
  logic              mid_tick, full_tick;
  logic [IW-1:0]     n_data, last_idx;

  function automatic logic [IW-1:0] data_bits(input logic l8);
    return l8 ? IW'(DATA_W) : IW'(DATA_W - 1);
  endfunction

  function automatic logic parity_on(input logic [1:0] pm);
    return (pm == PAR_EVEN) || (pm == PAR_ODD);
  endfunction

  function automatic logic parity_bad(input logic [DATA_W-1:0] w, input logic l8,
                                      input logic [1:0] pm, input logic pb);
    logic [DATA_W-1:0] mask;
    logic ones;
    mask = l8 ? '1 : {1'b0, {(DATA_W-1){1'b1}}};
    ones = ^(w & mask);
    case (pm)
      PAR_EVEN: return ones ^ pb;
      PAR_ODD:  return ~(ones ^ pb);
      default:  return 1'b0;
    endcase
  endfunction

  always_comb begin
    mid_tick     = tick && (cnt == CW'(HALF - 1));
    full_tick    = tick && (cnt == CW'(OSR - 1));
    start_reject = (state == ST_START) && mid_tick && line;
    n_data       = data_bits(len8);
    last_idx     = n_data + IW'(parity_on(par_mode)) - IW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      shreg      <= '0;
      par_q      <= 1'b0;
      frame_evt  <= 1'b0;
      frame_word <= '0;
      frame_perr <= 1'b0;
      frame_ferr <= 1'b0;
    end else begin
      frame_evt <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          ST_IDLE: if (tick && !line) begin
            state <= ST_START;
            cnt   <= '0;
          end
          ST_START: if (tick) begin
            if (mid_tick) begin
              cnt   <= '0;
              bidx  <= '0;
              shreg <= '0;
              state <= line ? ST_IDLE : ST_BITS;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_BITS: if (tick) begin
            if (full_tick) begin
              cnt <= '0;
              if (bidx < n_data) shreg <= shreg | (DATA_W'(line) << bidx);
              else               par_q <= line;
              if (bidx == last_idx) state <= ST_STOP;
              else                  bidx  <= bidx + IW'(1);
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_STOP: if (tick) begin
            if (full_tick) begin
              frame_evt  <= 1'b1;
              frame_word <= shreg;
              frame_perr <= parity_bad(shreg, len8, par_mode, par_q);
              frame_ferr <= !line;
              state      <= ST_IDLE;
              cnt        <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_FALSE_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_reject && en) |=> (state == ST_IDLE && !frame_evt)); // R2
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> !frame_evt); // R7
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == ST_IDLE)); // R10
endmodule

// File: rtl/rx_buf_status.sv
module rx_buf_status
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_evt,
  input  logic [DATA_W-1:0] frame_word,
  input  logic              frame_perr,
  input  logic              frame_ferr,
  input  logic              buf_rd,
  output logic [DATA_W-1:0] buf_data,
  output rx_flags_t         flags,
  output logic              done_pulse,
  output logic              err_pulse
);
  logic unread;
  rx_flags_t next_flags;

  always_comb begin
    next_flags.parity  = frame_perr;
    next_flags.framing = frame_ferr;
    next_flags.overrun = unread && !buf_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_data   <= '0;
      flags      <= '0;
      unread     <= 1'b0;
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      done_pulse <= frame_evt;
      err_pulse  <= frame_evt && (|next_flags);
      if (frame_evt) begin
        buf_data <= frame_word;
        flags    <= next_flags;
        unread   <= 1'b1;
      end else if (buf_rd) begin
        flags  <= '0;
        unread <= 1'b0;
      end
    end
  end

  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> done_pulse); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !frame_evt) |=> (flags == '0)); // R9
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_evt && !buf_rd) |=> ($stable(flags) && $stable(buf_data))); // R10
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import serial_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_en,
  input  logic              len8,
  input  logic [1:0]        par_mode,
  input  logic              rx_line,
  input  logic              buf_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic [2:0]        rx_status,
  output logic              rx_done,
  output logic              rx_err
);
  logic              line_s;
  logic              frame_evt, frame_perr, frame_ferr, start_reject;
  logic [DATA_W-1:0] frame_word;
  rx_flags_t         flags;

  rx_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(rx_line), .d_sync(line_s)
  );

  rx_frame_fsm #(.OSR(OSR), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .en(rx_en), .line(line_s),
    .len8(len8), .par_mode(par_mode), .frame_evt(frame_evt),
    .frame_word(frame_word), .frame_perr(frame_perr), .frame_ferr(frame_ferr),
    .start_reject(start_reject)
  );

  rx_buf_status #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt), .frame_word(frame_word),
    .frame_perr(frame_perr), .frame_ferr(frame_ferr), .buf_rd(buf_rd),
    .buf_data(rx_data), .flags(flags), .done_pulse(rx_done), .err_pulse(rx_err)
  );

  assign rx_status = flags;

  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !frame_evt); // R10
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> rx_done); // R7
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |=> !frame_evt); // R2
endmodule

// File: tb/serial_rx_engine_bench.sv
module serial_rx_engine_bench;
  localparam int OSR = 8;
  localparam int BITCLK = 2 * OSR;

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rx_en = 1'b0, len8 = 1'b1;
  logic [1:0] par_mode = 2'b00;
  logic rx_line = 1'b1, buf_rd = 1'b0;
  logic [7:0] rx_data;
  logic [2:0] rx_status;
  logic rx_done, rx_err;

  int n_chk = 0, n_bad = 0, done_cnt = 0, err_cnt = 0;
  logic [7:0] got_data;
  logic [2:0] got_stat;
  logic got_err;

  always #4 clk = ~clk;

  always @(posedge clk) os_tick <= rst_n ? ~os_tick : 1'b0;

  serial_rx_engine #(.OSR(OSR), .DATA_W(8)) u_serial_rx_engine (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en), .len8(len8),
    .par_mode(par_mode), .rx_line(rx_line), .buf_rd(buf_rd), .rx_data(rx_data),
    .rx_status(rx_status), .rx_done(rx_done), .rx_err(rx_err)
  );

  always @(negedge clk) if (rst_n && rx_done) begin
    done_cnt++;
    got_data = rx_data;
    got_stat = rx_status;
    got_err  = rx_err;
    if (rx_err) err_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_pbit(input logic [7:0] d, input logic l8, input logic [1:0] pm);
    logic ones;
    ones = l8 ? ^d : ^d[6:0];
    return (pm == 2'b10) ? ~ones : ones;
  endfunction

  function automatic logic [7:0] exp_word(input logic [7:0] d, input logic l8);
    return l8 ? d : {1'b0, d[6:0]};
  endfunction

  task automatic hold_bit(input logic v);
    rx_line = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic bad_stop);
    hold_bit(1'b0);
    for (int i = 0; i < (len8 ? 8 : 7); i++) hold_bit(d[i]);
    if (par_mode == 2'b01 || par_mode == 2'b10)
      hold_bit(exp_pbit(d, len8, par_mode) ^ flip_par);
    if (bad_stop) begin
      rx_line = 1'b0;
      repeat (2 * (OSR/2 + 2)) @(negedge clk);
      rx_line = 1'b1;
      repeat (BITCLK - 2 * (OSR/2 + 2)) @(negedge clk);
    end else begin
      hold_bit(1'b1);
    end
  endtask

  task automatic settle();
    rx_line = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
  endtask

  task automatic read_buf();
    buf_rd = 1'b1;
    @(negedge clk);
    buf_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int d0, e0;
    logic [7:0] d, a_data;
    logic [2:0] a_stat;
    logic perr;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 data", rx_data, 0);
    check("R1 status", rx_status, 0);
    check("R1 pulses", {rx_done, rx_err}, 0);
    rx_en = 1'b1;
    settle();

    // R3 directed 8-bit no parity
    d0 = done_cnt;
    send_frame(8'hA5, 1'b0, 1'b0); settle();
    check("R7 one done", done_cnt - d0, 1);
    check("R3 data 8bit", got_data, 8'hA5);
    check("R8 no err", got_err, 0);
    read_buf();

    // R3 7-bit with bit7 ignored
    len8 = 1'b0; d0 = done_cnt;
    send_frame(8'hFF, 1'b0, 1'b0); settle();
    check("R3 data 7bit", got_data, 8'h7F);
    read_buf(); len8 = 1'b1;

    // random frames (R3 R4 R7 R8)
    for (int k = 0; k < 30; k++) begin
      d = 8'($urandom);
      len8 = 1'($urandom);
      par_mode = 2'($urandom);
      perr = ($urandom % 4 == 0) && (par_mode == 2'b01 || par_mode == 2'b10);
      d0 = done_cnt;
      send_frame(d, perr, 1'b0); settle();
      check("R7 random done", done_cnt - d0, 1);
      check("R3 random data", got_data, exp_word(d, len8));
      check("R4 random status", got_stat, {2'b00, perr});
      check("R8 random err", got_err, perr);
      read_buf();
      check("R9 cleared by read", rx_status, 0);
    end

    // R4 mode 11 behaves as no parity
    par_mode = 2'b11; len8 = 1'b1;
    send_frame(8'h3C, 1'b0, 1'b0); settle();
    check("R4 mode11 data", got_data, 8'h3C);
    check("R4 mode11 status", got_stat, 0);
    read_buf();

    // R5 framing error, data still written
    par_mode = 2'b01;
    e0 = err_cnt;
    send_frame(8'h81, 1'b0, 1'b1); settle();
    check("R5 framing flag", got_stat, 3'b010);
    check("R7 bad data written", got_data, 8'h81);
    check("R8 err pulse", err_cnt - e0, 1);

    // R6 + R9 overrun replaces framing flag
    par_mode = 2'b00;
    send_frame(8'h42, 1'b0, 1'b0); settle();
    check("R6 overrun flag", got_stat, 3'b100);
    check("R9 replaced", got_stat[1], 0);
    check("R6 data newest", got_data, 8'h42);
    read_buf();
    check("R9 read clears", rx_status, 0);

    // R2 false start glitch
    d0 = done_cnt;
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    settle();
    check("R2 no event", done_cnt - d0, 0);
    send_frame(8'h96, 1'b0, 1'b0); settle();
    check("R2 recovers", got_data, 8'h96);
    read_buf();

    // R11 back-to-back frames with one stop bit
    d0 = done_cnt;
    send_frame(8'h11, 1'b0, 1'b0);
    send_frame(8'hE7, 1'b0, 1'b0); settle();
    check("R11 both frames", done_cnt - d0, 2);
    check("R11 second data", got_data, 8'hE7);
    check("R11 overrun", got_stat, 3'b100);

    // R10 abort mid-frame keeps buffer and status
    a_data = rx_data; a_stat = rx_status; d0 = done_cnt;
    hold_bit(1'b0); hold_bit(1'b1); hold_bit(1'b0); hold_bit(1'b1);
    rx_en = 1'b0;
    settle(); settle();
    check("R10 no event", done_cnt - d0, 0);
    check("R10 data kept", rx_data, a_data);
    check("R10 status kept", rx_status, a_stat);
    read_buf();
    rx_en = 1'b1;
    settle();
    send_frame(8'h5A, 1'b0, 1'b0); settle();
    check("R10 re-enabled", got_data, 8'h5A);
    check("R10 clean status", got_stat, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule